// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the fetch and execute logic of a small 8-bit processor core and owns the cycle timing of taking and leaving an interrupt. It keeps the pending request flags and the global interrupt enable. It looks for a request it may accept whenever the core reports a clean instruction boundary. Once it accepts one, it holds the core for a fixed four-cycle entry. In that time it writes the 16-bit return address to the stack one byte at a time, lowers the enable bit and hands the core the vector address of the winning request.

When the core finishes a return-from-interrupt instruction, the sequencer runs a four-cycle return. It reads both return-address bytes back, moves the stack pointer up by two, loads the restored address into the program counter and raises the enable bit again. A request that wakes a sleeping core pays four extra cycles before the normal entry starts. The enable bit is registered, so the instruction that follows an enable-setting instruction always runs before any interrupt is taken, and that holds even when the following instruction puts the core to sleep. The stack memory has a one-cycle read latency. The vector address is `VEC_BASE + id * VEC_STRIDE`, where `id` is the index of the accepted request line.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the enable bit is 0, the stack pointer equals `SP_RESET`, `seq_busy_o` is 0 and no stack write, stack read or PC load is driven.
- R2: An interrupt is accepted only at a qualifying boundary. That boundary has `boundary_i`=1, `mc_busy_i`=0, `sleep_i`=0 and `cli_i`=0, with the enable bit already 1 and at least one request flag set before that edge. `seq_busy_o` is then 1 for the next four cycles, and `pc_load_o` is 1 only in the fourth of them.
- R3: In entry cycle 1 the low return-address byte (`pc_i[7:0]` at acceptance) is written at the stack pointer. In entry cycle 2 the high byte is written at the stack pointer minus 1. The stack pointer ends two lower.
- R4: A boundary with `mc_busy_i`=1 is ignored: no entry starts and the enable bit is unchanged.
- R5: Entry clears the enable bit. At a qualifying boundary with no entry, `sei_i` sets it and `cli_i` clears it. `cli_i` also blocks acceptance at that same boundary.
- R6: The boundary at which `sei_i` sets the enable bit never accepts. The next qualifying boundary does accept.
- R7: While `sleep_i`=1 and idle, entry starts as soon as the enable bit is 1 and a flag is set. Four wait cycles come first, the pushes fall in cycles 5 and 6, and `pc_load_o` falls in cycle 8. Nothing happens while no flag is set.
- R8: On a qualifying boundary with `reti_i`=1, cycle 1 reads stack pointer+1 and cycle 2 reads stack pointer+2. Cycle 4 loads `{byte at +1, byte at +2}` into the PC, the stack pointer rises by two and the enable bit is 1 afterwards.
- R9: Among set flags the lowest index wins and its vector is loaded. Only that flag is cleared, and the others are taken at later boundaries.
- R10: With the enable bit 0, request flags stay pending and no entry starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_IRQ | Request pulses, one per line |
| boundary_i | input | 1 | Core is at the last cycle of an instruction |
| mc_busy_i | input | 1 | Multi-cycle instruction still running |
| sei_i | input | 1 | Finishing instruction sets the enable bit |
| cli_i | input | 1 | Finishing instruction clears the enable bit |
| reti_i | input | 1 | Finishing instruction is a return from interrupt |
| sleep_i | input | 1 | Core is asleep |
| pc_i | input | PC_W | Return address to save |
| stk_rdata_i | input | 8 | Stack read data, one cycle after the read |
| stk_we_o | output | 1 | Stack write strobe |
| stk_re_o | output | 1 | Stack read strobe |
| stk_addr_o | output | SP_W | Stack address |
| stk_wdata_o | output | 8 | Stack write data |
| sp_o | output | SP_W | Current stack pointer |
| pc_load_o | output | 1 | Load `pc_val_o` into the program counter |
| pc_val_o | output | PC_W | Vector or restored return address |
| gie_o | output | 1 | Global interrupt enable |
| seq_busy_o | output | 1 | Core held by an entry or return |

## Verification
A sequencer state that is off by one cycle moves `pc_load_o` or a stack strobe away from its expected cycle. That shows up within the same four-cycle window, or eight cycles for a wake-up. A wrong stack pointer shows as a wrong `stk_addr_o` on the very next push or pop, and as a wrong `sp_o` once the sequence ends. A lost or wrongly cleared request flag shows as a wrong `pc_val_o` vector, or as a missing entry at the next qualifying boundary. A wrong enable bit shows on `gie_o` in the cycle after the boundary, and as an entry that arrives one instruction early or late.

// File: rtl/ies_pkg.sv
package ies_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE,
    ST_E0, ST_E1, ST_E2, ST_E3,
    ST_R0, ST_R1, ST_R2, ST_R3
  } seq_st_e;
endpackage

// File: rtl/ies_pend.sv
module ies_pend #(
  parameter int N_IRQ = 8,
  parameter int ID_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             clr_en_i,
  output logic             any_o,
  output logic [ID_W-1:0]  id_o
);

  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] clr_mask;

  // lowest index wins
  always_comb begin
    any_o = |pend_q;
    id_o  = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (pend_q[i]) id_o = ID_W'(i);
    end
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_clr
    assign clr_mask[g] = clr_en_i && (id_o == ID_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_mask) | irq_i;
  end

  a_r9_clear_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |-> any_o);

  a_r9_single_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && irq_i == '0) |=> ($countones(pend_q) == $past($countones(pend_q)) - 1));

endmodule

// File: rtl/ies_fsm.sv
module ies_fsm
  import ies_pkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    boundary_i,
  input  logic    mc_busy_i,
  input  logic    sei_i,
  input  logic    cli_i,
  input  logic    reti_i,
  input  logic    sleep_i,
  input  logic    any_i,
  output seq_st_e st_o,
  output logic    accept_o,
  output logic    gie_o,
  output logic    busy_o
);

  localparam int CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

  seq_st_e           st_q, st_d;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d;
  logic              gie_q, gie_d;
  logic              bnd;

  assign bnd = boundary_i && !mc_busy_i && !sleep_i;

  always_comb begin
    st_d     = st_q;
    wcnt_d   = wcnt_q;
    gie_d    = gie_q;
    accept_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (sleep_i) begin
          if (gie_q && any_i) begin
            accept_o = 1'b1;
            gie_d    = 1'b0;
            wcnt_d   = CNT_W'(WAKE_CYC - 1);
            st_d     = ST_WAKE;
          end
        end else if (bnd) begin
          if (reti_i) begin
            st_d = ST_R0;
          end else if (gie_q && !cli_i && any_i) begin
            accept_o = 1'b1;
            gie_d    = 1'b0;
            st_d     = ST_E0;
          end else if (sei_i) begin
            gie_d = 1'b1;
          end else if (cli_i) begin
            gie_d = 1'b0;
          end
        end
      end
      ST_WAKE: begin
        if (wcnt_q == '0) st_d = ST_E0;
        else              wcnt_d = wcnt_q - 1'b1;
      end
      ST_E0: st_d = ST_E1;
      ST_E1: st_d = ST_E2;
      ST_E2: st_d = ST_E3;
      ST_E3: st_d = ST_IDLE;
      ST_R0: st_d = ST_R1;
      ST_R1: st_d = ST_R2;
      ST_R2: st_d = ST_R3;
      ST_R3: begin
        gie_d = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      gie_q  <= gie_d;
    end
  end

  assign st_o   = st_q;
  assign gie_o  = gie_q;
  assign busy_o = (st_q != ST_IDLE);

  a_r5_gie_off_in_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_E0) |-> !gie_q);

  a_r8_gie_on_after_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_R3) |=> gie_q);

  a_r4_busy_boundary_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && boundary_i && mc_busy_i && !sleep_i) |=> (st_q == ST_IDLE));

  a_r6_no_entry_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !gie_q) |=> (st_q != ST_E0 && st_q != ST_WAKE));

endmodule

// File: rtl/ies_stack.sv
module ies_stack
  import ies_pkg::*;
#(
  parameter int          SP_W     = 16,
  parameter int          PC_W     = 16,
  parameter int unsigned SP_RESET = 'hDF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  seq_st_e         st_i,
  input  logic            accept_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] vec_i,
  input  logic [7:0]      rdata_i,
  output logic            we_o,
  output logic            re_o,
  output logic [SP_W-1:0] addr_o,
  output logic [7:0]      wdata_o,
  output logic [SP_W-1:0] sp_o,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_val_o
);

  logic [SP_W-1:0] sp_q;
  logic [PC_W-1:0] ret_q, vec_q;
  logic [7:0]      hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= SP_W'(SP_RESET);
      ret_q <= '0;
      vec_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      if (accept_i) begin
        ret_q <= pc_i;
        vec_q <= vec_i;
      end
      unique case (st_i)
        ST_E0, ST_E1: sp_q <= sp_q - SP_W'(1);
        ST_R0:        sp_q <= sp_q + SP_W'(1);
        ST_R1: begin
          sp_q <= sp_q + SP_W'(1);
          hi_q <= rdata_i;
        end
        ST_R2:        lo_q <= rdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    we_o      = 1'b0;
    re_o      = 1'b0;
    addr_o    = sp_q;
    wdata_o   = '0;
    pc_load_o = 1'b0;
    pc_val_o  = '0;
    unique case (st_i)
      ST_E0: begin
        we_o    = 1'b1;
        wdata_o = ret_q[7:0];
      end
      ST_E1: begin
        we_o    = 1'b1;
        wdata_o = ret_q[15:8];
      end
      ST_E3: begin
        pc_load_o = 1'b1;
        pc_val_o  = vec_q;
      end
      ST_R0, ST_R1: begin
        re_o   = 1'b1;
        addr_o = sp_q + SP_W'(1);
      end
      ST_R3: begin
        pc_load_o = 1'b1;
        pc_val_o  = PC_W'({hi_q, lo_q});
      end
      default: ;
    endcase
  end

  assign sp_o = sp_q;

  a_r3_push_moves_sp_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (sp_q == $past(sp_q) - SP_W'(1)));

  a_r8_pop_moves_sp_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |=> (sp_q == $past(sp_q) + SP_W'(1)));

  a_r2_vector_after_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_E3) |-> $past(we_o, 2));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ies_pkg::*;
#(
  parameter int          N_IRQ      = 8,
  parameter int          PC_W       = 16,
  parameter int          SP_W       = 16,
  parameter int unsigned SP_RESET   = 'hDF,
  parameter int unsigned VEC_BASE   = 1,
  parameter int unsigned VEC_STRIDE = 2,
  parameter int          WAKE_CYC   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             boundary_i,
  input  logic             mc_busy_i,
  input  logic             sei_i,
  input  logic             cli_i,
  input  logic             reti_i,
  input  logic             sleep_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [7:0]       stk_rdata_i,
  output logic             stk_we_o,
  output logic             stk_re_o,
  output logic [SP_W-1:0]  stk_addr_o,
  output logic [7:0]       stk_wdata_o,
  output logic [SP_W-1:0]  sp_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_val_o,
  output logic             gie_o,
  output logic             seq_busy_o
);

  localparam int ID_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic            any;
  logic [ID_W-1:0] id;
  logic            accept;
  seq_st_e         st;
  logic [PC_W-1:0] vec;

  assign vec = PC_W'(VEC_BASE) + PC_W'(VEC_STRIDE) * PC_W'(id);

  ies_pend #(.N_IRQ(N_IRQ), .ID_W(ID_W)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .clr_en_i (accept),
    .any_o    (any),
    .id_o     (id)
  );

  ies_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary_i),
    .mc_busy_i  (mc_busy_i),
    .sei_i      (sei_i),
    .cli_i      (cli_i),
    .reti_i     (reti_i),
    .sleep_i    (sleep_i),
    .any_i      (any),
    .st_o       (st),
    .accept_o   (accept),
    .gie_o      (gie_o),
    .busy_o     (seq_busy_o)
  );

  ies_stack #(.SP_W(SP_W), .PC_W(PC_W), .SP_RESET(SP_RESET)) u_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_i      (st),
    .accept_i  (accept),
    .pc_i      (pc_i),
    .vec_i     (vec),
    .rdata_i   (stk_rdata_i),
    .we_o      (stk_we_o),
    .re_o      (stk_re_o),
    .addr_o    (stk_addr_o),
    .wdata_o   (stk_wdata_o),
    .sp_o      (sp_o),
    .pc_load_o (pc_load_o),
    .pc_val_o  (pc_val_o)
  );

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  localparam int          N   = 8;
  localparam int unsigned VB  = 1;
  localparam int unsigned VS  = 2;
  localparam logic [15:0] SP0 = 16'h00DF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq = '0;
  logic        bnd = 1'b0, mcb = 1'b0, sei = 1'b0, cli = 1'b0, reti = 1'b0, slp = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  rdata = '0;
  logic        we, re, pc_load, gie, busy;
  logic [15:0] addr, sp, pc_val;
  logic [7:0]  wdata;

  always #2 clk = ~clk;

  irq_entry_seq #(
    .N_IRQ(N), .PC_W(16), .SP_W(16), .SP_RESET(32'(SP0)),
    .VEC_BASE(VB), .VEC_STRIDE(VS), .WAKE_CYC(4)
  ) u_irq_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .boundary_i(bnd), .mc_busy_i(mcb),
    .sei_i(sei), .cli_i(cli), .reti_i(reti), .sleep_i(slp), .pc_i(pc),
    .stk_rdata_i(rdata), .stk_we_o(we), .stk_re_o(re), .stk_addr_o(addr),
    .stk_wdata_o(wdata), .sp_o(sp), .pc_load_o(pc_load), .pc_val_o(pc_val),
    .gie_o(gie), .seq_busy_o(busy)
  );

  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (we) mem[addr[7:0]] <= wdata;
    rdata <= mem[addr[7:0]];
  end

  int total = 0, bad = 0;
  bit          gie_m = 1'b0;
  logic [7:0]  pend_m = '0;
  logic [15:0] sp_m = SP0;
  logic [15:0] pcs [64];
  int          depth = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int low_id(logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic expect_entry(bit wake, logic [15:0] rpc, string tag);
    int id;
    logic [15:0] v;
    id = low_id(pend_m);
    v  = 16'(VB + VS * id);
    if (wake) begin
      for (int k = 0; k < 4; k++) begin
        chk({tag, " wake busy"}, busy, 1);
        chk({tag, " wake quiet"}, {we, pc_load}, 0);
        @(negedge clk);
      end
    end
    chk({tag, " R3 push lo we"}, we, 1);
    chk({tag, " R3 push lo addr"}, addr, sp_m);
    chk({tag, " R3 push lo data"}, wdata, rpc[7:0]);
    chk({tag, " R2 no early load"}, pc_load, 0);
    @(negedge clk);
    chk({tag, " R3 push hi we"}, we, 1);
    chk({tag, " R3 push hi addr"}, addr, sp_m - 16'd1);
    chk({tag, " R3 push hi data"}, wdata, rpc[15:8]);
    @(negedge clk);
    chk({tag, " R2 idle cycle"}, {we, pc_load}, 0);
    @(negedge clk);
    chk({tag, " R2 load"}, pc_load, 1);
    chk({tag, " R9 vector"}, pc_val, v);
    @(negedge clk);
    pend_m[id] = 1'b0;
    sp_m = sp_m - 16'd2;
    gie_m = 1'b0;
    pcs[depth] = rpc;
    depth++;
    chk({tag, " R2 done"}, busy, 0);
    chk({tag, " R3 sp"}, sp, sp_m);
    chk({tag, " R5 gie cleared"}, gie, 0);
  endtask

  task automatic expect_ret();
    chk("R8 pop hi", {re, addr}, {1'b1, sp_m + 16'd1});
    @(negedge clk);
    chk("R8 pop lo", {re, addr}, {1'b1, sp_m + 16'd2});
    @(negedge clk);
    chk("R8 gap", {re, pc_load}, 0);
    @(negedge clk);
    chk("R8 load", pc_load, 1);
    chk("R8 restored pc", pc_val, pcs[depth-1]);
    @(negedge clk);
    depth--;
    sp_m = sp_m + 16'd2;
    gie_m = 1'b1;
    chk("R8 sp", sp, sp_m);
    chk("R8 gie", gie, 1);
    chk("R8 done", busy, 0);
  endtask

  task automatic pulse(logic [7:0] m);
    irq = m;
    @(negedge clk);
    irq = '0;
    pend_m = pend_m | m;
    chk("R10 no spontaneous entry", busy, 0);
  endtask

  // kinds: 0 none, 1 entry, 2 wake entry, 3 return
  task automatic instr(bit s_sei, bit s_cli, bit s_reti, bit s_slp, bit s_mcb, logic [15:0] p);
    int kind;
    bit valid;
    string tg;
    bnd = 1'b1; sei = s_sei; cli = s_cli; reti = s_reti; slp = s_slp; mcb = s_mcb; pc = p;
    valid = !s_mcb && !s_slp;
    kind = 0;
    if (s_slp) begin
      if (gie_m && pend_m != 0) kind = 2;
    end else if (valid) begin
      if (s_reti) kind = 3;
      else if (gie_m && !s_cli && pend_m != 0) kind = 1;
      else if (s_sei) gie_m = 1'b1;
      else if (s_cli) gie_m = 1'b0;
    end
    @(negedge clk);
    bnd = 1'b0; sei = 1'b0; cli = 1'b0; reti = 1'b0; slp = 1'b0; mcb = 1'b0;
    case (kind)
      1: expect_entry(1'b0, p, "R2");
      2: expect_entry(1'b1, p, "R7");
      3: expect_ret();
      default: begin
        tg = s_mcb ? "R4" : (s_sei ? "R6" : (gie_m ? "R5" : "R10"));
        chk({tg, " no entry"}, busy, 0);
        chk({tg, " gie"}, gie, gie_m);
        chk({tg, " sp"}, sp, sp_m);
      end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", total, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 sp", sp, SP0);
    chk("R1 gie", gie, 0);
    chk("R1 quiet", {busy, we, re, pc_load}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // disabled: request stays pending
    pulse(8'h04);
    instr(0, 0, 0, 0, 0, 16'h0100);
    // shadow: enabling boundary does not accept
    instr(1, 0, 0, 0, 0, 16'h0101);
    instr(0, 0, 0, 0, 0, 16'h0102);
    // priority and nesting
    pulse(8'h28);
    instr(1, 0, 0, 0, 0, 16'h0200);
    instr(0, 0, 0, 0, 0, 16'h0201);
    instr(0, 0, 1, 0, 0, 16'h0300);
    instr(0, 0, 0, 0, 0, 16'h0301);
    instr(0, 0, 1, 0, 0, 16'h0302);
    instr(0, 0, 1, 0, 0, 16'h0303);
    // cli blocks at its own boundary, multi-cycle boundary ignored
    pulse(8'h01);
    instr(0, 1, 0, 0, 0, 16'h0400);
    instr(1, 0, 0, 0, 0, 16'h0401);
    instr(0, 0, 0, 0, 1, 16'h0402);
    instr(0, 0, 0, 0, 0, 16'h0403);
    instr(0, 0, 1, 0, 0, 16'h0404);
    // asleep, request arrives later
    pc = 16'h0500;
    slp = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R7 asleep no request", busy, 0);
    end
    irq = 8'h40;
    @(negedge clk);
    irq = '0;
    pend_m = pend_m | 8'h40;
    chk("R7 not yet", busy, 0);
    @(negedge clk);
    slp = 1'b0;
    expect_entry(1'b1, 16'h0500, "R7");
    instr(0, 0, 1, 0, 0, 16'h0501);
    // enable then sleep: sleep runs, then wake entry
    instr(0, 1, 0, 0, 0, 16'h0600);
    pulse(8'h02);
    instr(1, 0, 0, 0, 0, 16'h0601);
    instr(0, 0, 0, 1, 0, 16'h0602);
    instr(0, 0, 1, 0, 0, 16'h0603);

    for (int it = 0; it < 600; it++) begin
      int r;
      logic [15:0] rp;
      r  = $urandom_range(0, 9);
      rp = 16'($urandom);
      if (depth >= 40) r = 4;
      case (r)
        0, 1: pulse(8'($urandom & $urandom));
        2: instr(1, 0, 0, 0, 0, rp);
        3: instr(0, 1, 0, 0, 0, rp);
        4: instr(0, 0, depth > 0, 0, 0, rp);
        5: instr(0, 0, 0, 1, 0, rp);
        6: instr($urandom_range(0, 1) == 1, 0, 0, 0, 1, rp);
        default: instr(0, 0, 0, 0, 0, rp);
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule